// File: doc/BRIEF.md
# Flash Protected Range Checker

This block guards the address space of a serial flash controller. It holds a small bank of range registers. Each register describes a window of flash, aligned to 4 KiB pages, together with two independent enables: one that blocks reads and one that blocks writes and erases. Every flash cycle the controller wants to start is presented as a request carrying a 24-bit address and a kind bit. One clock later the block answers with either a grant or an error. An error means the controller must fail that cycle and not touch the flash.

Software fills the range registers through a one-word write port and then sets a lock-down bit. The ranges are enforced only while lock-down is set. Lock-down also freezes the registers. Only reset clears lock-down, and reset also clears every range.

Top module: `fpr_guard`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_grant`, `rsp_error` and `locked` are 0, and every range register is cleared. After a new lock-down, a request to any address is therefore granted until ranges are written again.
- R2: A request taken on a clock edge is answered on the next edge. `rsp_valid` is then 1 and exactly one of `rsp_grant` and `rsp_error` is 1. With no request, all three outputs are 0 on the following cycle.
- R3: While `locked` is 0, every request is granted, whatever the range registers hold.
- R4: A `cfg_lock` pulse sets `locked` on the next edge. `locked` stays 1 through further pulses and register writes until reset.
- R5: While locked, a write request (`req_is_write`=1) gets `rsp_error` if its address lies inside a range whose write enable, bit 31 of the range word, is 1.
- R6: While locked, a read request (`req_is_write`=0) gets `rsp_error` if its address lies inside a range whose read enable, bit 15, is 1. The read enable never blocks writes, and the write enable never blocks reads.
- R7: The lower limit is word bits 12:0 and the upper limit is word bits 28:16. Both hold flash address bits 24:12. The range runs from lower·4096 to upper·4096+4095, both ends included. The addresses just outside either end are granted.
- R8: A range whose lower limit is above its upper limit matches no address.
- R9: There are five range registers, selected by `cfg_idx` 0 to 4. A match in any one of them blocks the cycle, and the last index takes part like the others. A write with `cfg_idx` of 5 or more changes nothing.
- R10: While `locked` is 1, writes on the configuration port are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Range register write strobe |
| cfg_idx | input | 3 | Range register index |
| cfg_wdata | input | 32 | Range word: write enable, upper limit, read enable, lower limit |
| cfg_lock | input | 1 | Sets lock-down |
| req_valid | input | 1 | Flash cycle request strobe |
| req_addr | input | 24 | Flash cycle byte address |
| req_is_write | input | 1 | 1 for write or erase, 0 for read |
| rsp_valid | output | 1 | Answer present |
| rsp_grant | output | 1 | Cycle may proceed |
| rsp_error | output | 1 | Cycle blocked, fail with error |
| locked | output | 1 | Lock-down state |

## Verification
The hardest case to reach from the ports is a write that arrives after lock-down and would have opened or widened a range. Its only visible effect is that later requests are still answered according to the old ranges. The stimulus handles this by writing, after lock-down, a range word that would cover all of flash, to an unused index. It also writes an all-covering word before lock-down to index 5. It then sends requests to addresses that only those words could cover and expects grants.

Page-edge addresses on both sides of each limit, a reversed range, and a range whose upper limit carries address bit 24 exercise the comparison edges. Requests are issued back to back, so consecutive answers must not mix.

// File: rtl/fpr_pkg.sv
// Package: shared types and field layout for the protected range checker.
// Assumes 4 KiB pages and 13-bit page limits (flash address bits 24:12).
package fpr_pkg;

    localparam int FPR_PAGE_LSB = 12;
    localparam int FPR_LIM_W    = 13;
    localparam int FPR_FULL_W   = FPR_LIM_W + FPR_PAGE_LSB;

    typedef struct packed {
        logic                 wr_en;
        logic                 rd_en;
        logic [FPR_LIM_W-1:0] upper;
        logic [FPR_LIM_W-1:0] lower;
    } fpr_range_t;

    // Unpack a software range word into its fields.
    function automatic fpr_range_t fpr_unpack(input logic [31:0] w);
        fpr_range_t r;
        r.wr_en = w[31];
        r.upper = w[28:16];
        r.rd_en = w[15];
        r.lower = w[12:0];
        return r;
    endfunction

endpackage

// File: rtl/fpr_bank.sv
// Module: range register bank with sticky lock-down.
// Holds N_RANGES range words. A write is taken only while unlocked and only
// for an index below N_RANGES. A lock request sets lock-down until reset.
module fpr_bank
    import fpr_pkg::*;
#(
    parameter int N_RANGES = 5,
    parameter int IDX_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [IDX_W-1:0]            cfg_idx,
    input  logic [31:0]                 cfg_wdata,
    input  logic                        cfg_lock,
    output fpr_range_t [N_RANGES-1:0]   ranges,
    output logic                        locked
);

    logic       wr_ok;
    fpr_range_t new_range;
    logic       unused_bits;

    assign wr_ok       = cfg_we && !locked;
    assign new_range   = fpr_unpack(cfg_wdata);
    assign unused_bits = ^{cfg_wdata[30:29], cfg_wdata[14:13]};

    // Lock-down flag: set by request, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
        end else if (cfg_lock) begin
            locked <= 1'b1;
        end
    end

    for (genvar g = 0; g < N_RANGES; g++) begin : g_entry
        // Range entry g: load from the port when selected and unlocked.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ranges[g] <= '0;
            end else if (wr_ok && (cfg_idx == IDX_W'(g))) begin
                ranges[g] <= new_range;
            end
        end
    end

endmodule

// File: rtl/fpr_match.sv
// Module: single-range comparator.
// Compares the page number of the address against one range and reports a
// hit when the enable for the request kind is set. Assumes ADDR_W <= 25.
module fpr_match
    import fpr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  fpr_range_t        range_i,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output logic              hit
);

    logic [FPR_FULL_W-1:0]   wide;
    logic [FPR_LIM_W-1:0]    page;
    logic                    enabled;
    logic                    unused_low;

    assign wide       = FPR_FULL_W'(addr);
    assign page       = wide[FPR_FULL_W-1:FPR_PAGE_LSB];
    assign unused_low = ^wide[FPR_PAGE_LSB-1:0];

    // Hit when enabled for this kind and page lies inside the inclusive window.
    always_comb begin
        enabled = is_write ? range_i.wr_en : range_i.rd_en;
        hit     = enabled && (page >= range_i.lower) && (page <= range_i.upper);
    end

endmodule

// File: rtl/fpr_guard.sv
// Module: protected range checker top.
// Checks each request against all ranges in parallel and answers one cycle
// later with grant or error. Enforcement applies only while locked.
module fpr_guard
    import fpr_pkg::*;
#(
    parameter int N_RANGES = 5,
    parameter int ADDR_W   = 24,
    localparam int IDX_W   = (N_RANGES > 1) ? $clog2(N_RANGES + 1) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              cfg_lock,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_write,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_error,
    output logic              locked
);

    fpr_range_t [N_RANGES-1:0] ranges;
    logic [N_RANGES-1:0]       hits;
    logic                      block;

    fpr_bank #(
        .N_RANGES (N_RANGES),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_lock  (cfg_lock),
        .ranges    (ranges),
        .locked    (locked)
    );

    for (genvar g = 0; g < N_RANGES; g++) begin : g_cmp
        fpr_match #(
            .ADDR_W (ADDR_W)
        ) u_match (
            .range_i  (ranges[g]),
            .addr     (req_addr),
            .is_write (req_is_write),
            .hit      (hits[g])
        );
    end

    // Block decision: any range hit counts, but only under lock-down.
    assign block = locked && (|hits);

    // Response register: one answer per request, one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_error <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_grant <= req_valid && !block;
            rsp_error <= req_valid && block;
        end
    end

endmodule

// File: rtl/fpr_guard_chk.sv
// Module: assertion checker for fpr_guard, attached by bind.
// Checks response timing, outcome exclusivity and lock behaviour.
module fpr_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_lock,
    input logic req_valid,
    input logic rsp_valid,
    input logic rsp_grant,
    input logic rsp_error,
    input logic locked
);

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_grant && !rsp_error));

    assert_single_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_grant, rsp_error}) == 1));

    assert_grant_when_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !locked) |=> rsp_grant);

    assert_lock_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> locked);

    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

endmodule

bind fpr_guard fpr_guard_chk u_chk (.*);

// File: tb/sim_fpr_guard.sv
// Scoreboard bench: a driver pushes expected outcomes, a monitor compares.
module sim_fpr_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_lock = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_is_write = 1'b0;
    logic        rsp_valid, rsp_grant, rsp_error, locked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    bit    exp_q[$];
    string tag_q[$];

    bit          m_lock;
    bit          m_wr [5];
    bit          m_rd [5];
    logic [12:0] m_lo [5];
    logic [12:0] m_hi [5];

    always #5 clk = ~clk;

    fpr_guard u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_lock(cfg_lock), .req_valid(req_valid),
        .req_addr(req_addr), .req_is_write(req_is_write), .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant), .rsp_error(rsp_error), .locked(locked)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic void model_clear();
        m_lock = 0;
        for (int i = 0; i < 5; i++) begin
            m_wr[i] = 0; m_rd[i] = 0; m_lo[i] = '0; m_hi[i] = '0;
        end
    endfunction

    function automatic bit model_block(input logic [23:0] a, input bit wr);
        logic [12:0] pg;
        bit b;
        pg = {1'b0, a[23:12]};
        b = 0;
        for (int i = 0; i < 5; i++)
            if ((wr ? m_wr[i] : m_rd[i]) && pg >= m_lo[i] && pg <= m_hi[i]) b = 1;
        return m_lock && b;
    endfunction

    task automatic quiet();
        cfg_we = 0; cfg_lock = 0; req_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); quiet(); end
    endtask

    task automatic cfg_write(input int idx, input logic [31:0] w);
        @(negedge clk);
        quiet();
        cfg_we = 1; cfg_idx = 3'(idx); cfg_wdata = w;
        if (!m_lock && idx < 5) begin
            m_wr[idx] = w[31]; m_rd[idx] = w[15];
            m_hi[idx] = w[28:16]; m_lo[idx] = w[12:0];
        end
    endtask

    task automatic lock_op();
        @(negedge clk);
        quiet();
        cfg_lock = 1;
        m_lock = 1;
    endtask

    task automatic req(input logic [23:0] a, input bit wr, input string tag);
        @(negedge clk);
        quiet();
        req_valid = 1; req_addr = a; req_is_write = wr;
        exp_q.push_back(model_block(a, wr));
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each answer against the oldest expectation.
    always @(posedge clk) begin
        #2;
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R2 unexpected answer", 1, 0);
            end else begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check((rsp_error == e) && (rsp_grant == !e), t,
                      {rsp_grant, rsp_error}, {!e, e});
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        check(rsp_valid == 0 && rsp_grant == 0 && rsp_error == 0, "R1 reset outputs",
              {rsp_valid, rsp_grant, rsp_error}, 0);
        check(locked == 0, "R1 reset lock", locked, 0);
        rst_n = 1;

        // Program ranges before lock-down.
        cfg_write(0, 32'h8000_0000 | (32'h01F << 16) | 32'h010);    // write-protect pages 0x010..0x01F
        req(24'h015000, 1, "R3 unlocked write in range");
        cfg_write(1, 32'h0000_8000 | (32'h100 << 16) | 32'h100);    // read-protect page 0x100
        cfg_write(2, 32'h8000_8000 | (32'h040 << 16) | 32'h050);    // reversed
        cfg_write(4, 32'h8000_8000 | (32'h1FFF << 16) | 32'h0FFF);  // top page, upper uses bit 24
        cfg_write(5, 32'h8000_8000 | (32'h1FFF << 16));             // bad index, all flash
        req(24'h100000, 0, "R3 unlocked read in range");
        lock_op();
        idle(1);
        check(locked == 1, "R4 lock set", locked, 1);

        cfg_write(3, 32'h8000_8000 | (32'h1FFF << 16));             // after lock, ignored
        req(24'h010000, 1, "R7 lower edge");
        req(24'h00FFFF, 1, "R7 below lower");
        req(24'h01FFFF, 1, "R7 upper edge");
        req(24'h020000, 1, "R7 above upper");
        req(24'h015000, 1, "R5 write in write range");
        req(24'h015000, 0, "R6 read in write-only range");
        req(24'h100000, 0, "R6 read in read range");
        req(24'h100FFF, 0, "R6 read at read range end");
        req(24'h100800, 1, "R6 write in read-only range");
        req(24'h0FFFFF, 0, "R7 read below read range");
        req(24'h045000, 1, "R8 reversed range write");
        req(24'h048000, 0, "R8 reversed range read");
        req(24'hFFFFFF, 0, "R9 last index read");
        req(24'hFFF000, 1, "R9 last index write");
        req(24'h800000, 1, "R9 index 5 ignored");
        req(24'h300000, 0, "R10 write after lock ignored");
        lock_op();
        cfg_write(0, 32'h0);
        idle(1);
        check(locked == 1, "R4 lock sticky", locked, 1);
        req(24'h018000, 1, "R10 clear after lock ignored");
        idle(3);
        check(exp_q.size() == 0, "R2 all answered", exp_q.size(), 0);

        // Reset clears lock and ranges.
        @(negedge clk);
        rst_n = 0;
        idle(2);
        check(locked == 0 && rsp_valid == 0, "R1 reset again", {locked, rsp_valid}, 0);
        rst_n = 1;
        model_clear();
        lock_op();
        req(24'h010000, 1, "R1 ranges cleared");
        req(24'h100000, 0, "R1 ranges cleared read");
        idle(3);
        check(exp_q.size() == 0, "R2 all answered at end", exp_q.size(), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule